// File: doc/BRIEF.md
# Dual-Rate Over-Current Trip Filter

This block debounces the digital output of an over-current comparator and cuts the gate drive of a hot-swap pass transistor. The comparator goes high when the drop across the series sense resistor is above roughly 50 mV. The block does not react to every high level on that flag. It takes a sample at fixed instants and trips only when a fixed number of samples in a row all show over-current.

The sample period depends on the power phase. While the load is still powering up, `gates_on_i` is low and the flag is sampled every 500 ns, so eight hits give a 4 µs response to a shorted card. Once the pass transistors are fully enhanced, `gates_on_i` goes high and the period becomes 2 µs, so the same eight hits need 16 µs. This makes the block more tolerant of noise during long steady operation.

A trip is latched: the gate stays off and the trip flag stays set until `rearm_i` is pulsed or reset is applied. A change of phase and a re-arm both restart the sample timer and the hit count, so no partial run carries across them.

Top module: `oc_trip_filter`

## Requirements
- R1: While reset is applied and after it is released, `gate_en_o` is 1 and `tripped_o` is 0.
- R2: With `gates_on_i` low and the clock at 50 MHz, the flag is sampled every 25 cycles (500 ns). If the flag is high from a re-arm edge onward, `gate_en_o` falls and `tripped_o` rises on the same edge, exactly 200 cycles after that re-arm edge (8 samples).
- R3: With `gates_on_i` high, the flag is sampled every 100 cycles (2 µs). A steady over-current trips exactly 800 cycles after the re-arm edge.
- R4: A sample that finds the flag low resets the hit run to zero. After a miss at sample m, the trip comes at sample m+8.
- R5: Flag levels that occur only between sample instants have no effect on when the trip happens.
- R6: After a trip, `gate_en_o` stays 0 and `tripped_o` stays 1 whatever the flag does, until re-arm or reset.
- R7: A high `rearm_i` at a clock edge clears the trip on that edge and restarts the sample timer and the hit run. With the flag low, no trip follows.
- R8: A change of `gates_on_i` in either direction restarts the sample timer and clears the hit run. A trip after the change needs 8 full samples at the new rate, counted from the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (50 MHz by default) |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_flag_i | input | 1 | Comparator flag, high when sense drop exceeds threshold |
| gates_on_i | input | 1 | High once the pass transistors are fully on (slow rate) |
| rearm_i | input | 1 | Clears a latched trip and restarts sampling |
| gate_en_o | output | 1 | Gate-drive enable, low after a trip |
| tripped_o | output | 1 | Latched trip indication |

## Verification
The hardest situations to reach from the ports need a comparator miss placed on exactly one sample instant, or a phase change made in the middle of a partial run. The timer phase is internal, so the bench uses the re-arm pulse as a known time origin, because it restarts the timer. From that origin it counts edges to drop the flag at the chosen sample, or one cycle off a sample. For every miss position in the fast phase the bench predicts the trip edge as (miss index + 8) times the period. It then checks both the edge before and the edge of the trip.

// File: rtl/oc_trip_pkg.sv
// Package: shared helpers for the over-current trip filter.
// Assumes clock frequencies that are whole multiples of 1 kHz.
package oc_trip_pkg;

    // Number of clock cycles in a period given in nanoseconds.
    function automatic int cycles_for_ns(input int clk_hz, input int period_ns);
        return ((clk_hz / 1000) * period_ns) / 1_000_000;
    endfunction

    // Power phase that selects the sample rate.
    typedef enum logic {
        PH_START = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

endpackage

// File: rtl/oc_sample_timer.sv
// Module: oc_sample_timer
// Produces a one-cycle sample strobe at one of two periods.
// Assumes: both periods are at least 2 cycles. When restart is high the
// counter goes back to zero and no strobe is issued in that cycle.
module oc_sample_timer #(
    parameter int FAST_DIV = 25,
    parameter int SLOW_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow_sel,
    output logic strobe
);
    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int TW = $clog2(MAX_DIV);
    localparam logic [TW-1:0] FAST_LAST = TW'(FAST_DIV - 1);
    localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_DIV - 1);

    logic [TW-1:0] tick_q;
    logic [TW-1:0] last_val;

    // Selects the terminal count for the current phase.
    always_comb last_val = slow_sel ? SLOW_LAST : FAST_LAST;

    // Advances the divider, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_q <= '0;
        end else if (tick_q >= last_val) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // Raises the strobe in the last cycle of each period.
    always_comb strobe = !restart && (tick_q == last_val);
endmodule

// File: rtl/oc_run_counter.sv
// Module: oc_run_counter
// Counts consecutive sampled hits and flags the sample that completes a run.
// Assumes: clear has priority. A sampled miss empties the run.
module oc_run_counter #(
    parameter int HITS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      strobe,
    input  logic                      hit,
    output logic                      run_full,
    output logic [$clog2(HITS+1)-1:0] run_cnt
);
    localparam int CW = $clog2(HITS + 1);
    localparam logic [CW-1:0] LAST_HIT = CW'(HITS - 1);

    // Updates the run length on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_cnt <= '0;
        end else if (strobe) begin
            if (!hit || run_cnt == LAST_HIT) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Reports the hit that completes a full run.
    always_comb run_full = strobe && hit && (run_cnt == LAST_HIT);
endmodule

// File: rtl/oc_trip_latch.sv
// Module: oc_trip_latch
// Holds the trip state until it is cleared. Clear wins over set.
module oc_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_trip,
    input  logic clr_trip,
    output logic tripped
);
    // Sets on a completed run and clears on re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_trip) begin
            tripped <= 1'b0;
        end else if (set_trip) begin
            tripped <= 1'b1;
        end
    end
endmodule

// File: rtl/oc_trip_filter.sv
// Module: oc_trip_filter (top)
// Filters an over-current comparator flag with a sample rate chosen by the
// power phase and latches a gate-drive shutdown after a run of hits.
// Assumes: the flag and gates_on_i are already synchronous to clk.
module oc_trip_filter
    import oc_trip_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int FAST_NS    = 500,
    parameter int SLOW_NS    = 2000,
    parameter int HIT_COUNT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag_i,
    input  logic gates_on_i,
    input  logic rearm_i,
    output logic gate_en_o,
    output logic tripped_o
);
    localparam int FAST_DIV = cycles_for_ns(CLK_HZ, FAST_NS);
    localparam int SLOW_DIV = cycles_for_ns(CLK_HZ, SLOW_NS);
    localparam int CW = $clog2(HIT_COUNT + 1);

    phase_e          phase_q;
    phase_e          phase_now;
    logic            mode_chg;
    logic            restart;
    logic            smp_stb;
    logic            run_full;
    logic [CW-1:0]   run_cnt;

    // Decodes the requested phase from the gate status.
    always_comb phase_now = gates_on_i ? PH_RUN : PH_START;

    // Stores the phase seen last cycle to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_START;
        end else begin
            phase_q <= phase_now;
        end
    end

    // A phase change or re-arm restarts sampling from zero.
    always_comb begin
        mode_chg = (phase_now != phase_q);
        restart  = mode_chg || rearm_i;
    end

    oc_sample_timer #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .slow_sel (phase_now == PH_RUN),
        .strobe   (smp_stb)
    );

    oc_run_counter #(
        .HITS     (HIT_COUNT)
    ) runs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart || tripped_o),
        .strobe   (smp_stb),
        .hit      (oc_flag_i),
        .run_full (run_full),
        .run_cnt  (run_cnt)
    );

    oc_trip_latch latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_trip (run_full),
        .clr_trip (rearm_i),
        .tripped  (tripped_o)
    );

    // Gate drive is enabled only while no trip is latched.
    always_comb gate_en_o = !tripped_o;
endmodule

// File: rtl/oc_trip_filter_chk.sv
// Module: oc_trip_filter_chk
// Temporal checks on the trip filter, attached to the top by bind.
module oc_trip_filter_chk #(
    parameter int HITS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      oc_flag_i,
    input logic                      rearm_i,
    input logic                      gate_en_o,
    input logic                      tripped_o,
    input logic                      smp_stb,
    input logic                      mode_chg,
    input logic [$clog2(HITS+1)-1:0] run_cnt
);
    localparam int CW = $clog2(HITS + 1);
    localparam logic [CW-1:0] LAST_HIT = CW'(HITS - 1);

    p_run_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LAST_HIT);

    p_trip_on_hit_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped_o) |-> $past(smp_stb && oc_flag_i));

    p_miss_empties_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !oc_flag_i |=> run_cnt == '0);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);

    p_trip_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tripped_o && !rearm_i |=> tripped_o && !gate_en_o);

    p_rearm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> !tripped_o && gate_en_o);

    p_phase_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> run_cnt == '0);
endmodule

bind oc_trip_filter oc_trip_filter_chk #(
    .HITS (HIT_COUNT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_flag_i (oc_flag_i),
    .rearm_i   (rearm_i),
    .gate_en_o (gate_en_o),
    .tripped_o (tripped_o),
    .smp_stb   (smp_stb),
    .mode_chg  (mode_chg),
    .run_cnt   (run_cnt)
);

// File: tb/oc_trip_filter_tb_top.sv
// Bench: sweeps miss positions and phase changes, predicting trip edges
// from period arithmetic relative to a re-arm edge.
module oc_trip_filter_tb_top;
    localparam int FP = 25;   // 500 ns at 50 MHz
    localparam int SP = 100;  // 2 us at 50 MHz
    localparam int HN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0;
    logic gon = 1'b0;
    logic rearm = 1'b0;
    logic gate_en;
    logic tripped;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    oc_trip_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_flag_i  (oc),
        .gates_on_i (gon),
        .rearm_i    (rearm),
        .gate_en_o  (gate_en),
        .tripped_o  (tripped)
    );

    // Advance k rising edges, then settle at the following falling edge.
    task automatic wait_edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    // Compare both outputs against the expected enable level.
    task automatic expect_gate(input logic exp_en, input string req, input string what);
        n_chk++;
        if (gate_en !== exp_en || tripped !== !exp_en) begin
            n_bad++;
            $display("FAIL %s %s: gate_en=%0b tripped=%0b expected gate_en=%0b tripped=%0b",
                     req, what, gate_en, tripped, exp_en, !exp_en);
        end
    endtask

    // Pulse re-arm for one edge E; returns at the falling edge after E.
    task automatic arm();
        @(negedge clk);
        rearm = 1'b1;
        wait_edges(1);
        rearm = 1'b0;
    endtask

    // Steady over-current with an optional miss at sample miss_at.
    task automatic trip_run(input int p, input int miss_at, input string req);
        arm();
        if (miss_at > 0) begin
            wait_edges(miss_at * p - 1);
            oc = 1'b0;
            wait_edges(1);
            oc = 1'b1;
        end
        wait_edges(HN * p - 1);
        expect_gate(1'b1, req, "edge before trip");
        wait_edges(1);
        expect_gate(1'b0, req, "trip edge");
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_gate(1'b1, "R1", "during reset");
        rst_n = 1'b1;
        wait_edges(2);
        expect_gate(1'b1, "R1", "after reset");

        // R2: fast-phase trip latency
        oc = 1'b1;
        trip_run(FP, 0, "R2");

        // R4: every miss position in the fast phase
        for (int m = 1; m <= HN; m++) trip_run(FP, m, "R4");

        // R5: a low flag one cycle off a sample instant is ignored
        arm();
        wait_edges(FP + 2);
        oc = 1'b0;
        wait_edges(1);
        oc = 1'b1;
        wait_edges(7 * FP - 4);
        expect_gate(1'b1, "R5", "edge before trip");
        wait_edges(1);
        expect_gate(1'b0, "R5", "trip edge");

        // R6: trip stays latched whatever the flag does
        oc = 1'b0;
        wait_edges(3 * SP);
        expect_gate(1'b0, "R6", "flag low");
        oc = 1'b1;
        wait_edges(50);
        expect_gate(1'b0, "R6", "flag high again");

        // R7: re-arm clears, no trip without over-current
        oc = 1'b0;
        arm();
        expect_gate(1'b1, "R7", "right after re-arm");
        wait_edges(20 * FP);
        expect_gate(1'b1, "R7", "quiet flag");

        // R3: slow-phase trip latency and misses
        oc = 1'b1;
        gon = 1'b1;
        trip_run(SP, 0, "R3");
        trip_run(SP, 1, "R4");
        trip_run(SP, 4, "R4");
        trip_run(SP, HN, "R4");

        // R8: fast to slow change with a partial run
        gon = 1'b0;
        arm();
        wait_edges(5 * FP);
        gon = 1'b1;
        wait_edges(1);
        wait_edges(HN * SP - 1);
        expect_gate(1'b1, "R8", "fast->slow edge before trip");
        wait_edges(1);
        expect_gate(1'b0, "R8", "fast->slow trip edge");

        // R8: slow to fast change with a partial run
        arm();
        wait_edges(3 * SP);
        gon = 1'b0;
        wait_edges(1);
        wait_edges(HN * FP - 1);
        expect_gate(1'b1, "R8", "slow->fast edge before trip");
        wait_edges(1);
        expect_gate(1'b0, "R8", "slow->fast trip edge");

        // R1: reset clears a latched trip
        rst_n = 1'b0;
        wait_edges(1);
        expect_gate(1'b1, "R1", "reset over trip");
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule